// File: doc/BRIEF.md
# Synchronous Serial Port Engine

This block is a master-side synchronous serial port. Software places words into an 8-entry transmit queue through a small register interface. Once the port is enabled, the engine serialises each word MSB first on `txd`, drives a bit clock on `sclk` and a frame signal on `sfrm`, and collects the same number of bits into an 8-entry receive queue. Software reads those words back through the same data address. The bit clock is divided down from the system clock. Each word can be 4 to 16 bits long.

Two frame formats are built. In the first, the frame line is held low for the whole word. In the second, a single high pulse one bit period long precedes the data. Clock idle level and clock phase can both be selected. An internal loopback feeds the transmitted bits straight into the receiver for self-test. Two interrupt lines request service when the transmit queue has drained to half or below, or when the receive queue has filled to half or above. A sticky overrun flag records words that were lost because the receive queue was full.

Top module: `ssp_engine`

## Requirements
- R1: Bits 3:0 of control word 0 (address 0) hold the word size minus one, so words are 4 to 16 bits long. Each word is sent MSB first with exactly that many leading clock edges.
- R2: Bits 15:8 of control word 0 hold a divisor D. Consecutive leading clock edges are 2*(D+1) system clock cycles apart.
- R3: Bit 7 of control word 0 enables the port. While it is 0, no frame starts and any queued transmit word stays queued until the bit is set.
- R4: Bits 5:4 of control word 0 select the format. With value 0, `sfrm` is low from frame start to the last trailing edge and high when idle. Values 2 and 3 start no transfer.
- R5: With format value 1, `sfrm` idles low and is high for exactly one bit period at frame start. The first leading clock edge follows half a bit period after that pulse ends.
- R6: Bit 3 of control word 1 (address 1) sets the level at which `sclk` idles. Each leading edge moves `sclk` away from that level.
- R7: In format 0, bit 4 of control word 1 places the first leading edge half a bit period (1) or a full bit period (0) after `sfrm` falls. `txd` changes only on trailing edges and at frame start.
- R8: Bit 2 of control word 1 selects loopback. When it is 1, the receiver samples the internal transmit bit and `rxd` is ignored. When it is 0, the receiver samples `rxd` on leading edges.
- R9: A read of address 2 returns the oldest received word, right-justified with zeros above the word size. A read of address 2 with the receive queue empty returns 0.
- R10: Both queues are 8 entries deep. A write to address 2 while the transmit queue is full is dropped.
- R11: The status word at address 3 is, from bit 0 upward: transmit queue not full, receive queue not empty, busy, transmit level at most half, receive level at least half, overrun. All other bits are 0. Busy is 1 while a word is shifting, or while the port is enabled and the transmit queue holds data.
- R12: A word that completes while the receive queue is full is discarded and sets the overrun bit. Writing 1 to status bit 5 clears it.
- R13: `tx_irq` equals bit 1 of control word 1 AND "transmit level at most half". `rx_irq` equals bit 0 of control word 1 AND "receive level at least half". Both are registered one cycle behind the queue levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe, data on `rdata` next cycle |
| addr | input | 2 | Register select: 0 control 0, 1 control 1, 2 data, 3 status |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| sclk | output | 1 | Serial bit clock |
| sfrm | output | 1 | Frame signal |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |
| tx_irq | output | 1 | Transmit service request |
| rx_irq | output | 1 | Receive service request |

## Verification
The hardest state to reach from the ports is a completed word arriving at a full receive queue. Reaching it takes eight words to cross the serial link without a single read in between, and then one more word to finish shifting. The bench gets there by filling the transmit queue while the port is disabled, with one write past full to show that extra write is dropped. It then enables the port in loopback with the shortest word and the fastest clock, waits for the queue to fill, and queues one last word. Reading back the eight words in order shows that the late word was discarded and the overflow write never entered.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int DW = 16;

  typedef enum logic [1:0] {
    FMT_SPI  = 2'd0,
    FMT_TI   = 2'd1,
    FMT_MW   = 2'd2,
    FMT_RSV  = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    A_CTRL0 = 2'd0,
    A_CTRL1 = 2'd1,
    A_DATA  = 2'd2,
    A_STAT  = 2'd3
  } addr_e;

  typedef struct packed {
    logic [7:0] scr;
    logic       en;
    logic       rsv;
    fmt_e       fmt;
    logic [3:0] dsz;
  } ctrl0_t;

  typedef struct packed {
    logic [10:0] rsv;
    logic        pha;
    logic        pol;
    logic        lpbk;
    logic        tx_ie;
    logic        rx_ie;
  } ctrl1_t;
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     push,
  input  logic                     pop,
  input  logic [W-1:0]             din,
  output logic [W-1:0]             dout,
  output logic                     full,
  output logic                     empty,
  output logic [$clog2(DEPTH):0]   count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  // storage array kept free of reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  // R10
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R10
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> $stable(count));
endmodule

// File: rtl/ssp_shift.sv
module ssp_shift import ssp_pkg::*; (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  fmt_e          fmt,
  input  logic [3:0]    dsz,
  input  logic [7:0]    scr,
  input  logic          pol,
  input  logic          pha,
  input  logic          lpbk,
  input  logic          tx_empty,
  input  logic [DW-1:0] tx_word,
  input  logic          rxd,
  output logic          tx_pop,
  output logic          rx_push,
  output logic [DW-1:0] rx_word,
  output logic          active,
  output logic          sclk,
  output logic          sfrm,
  output logic          txd
);
  typedef enum logic {S_IDLE, S_RUN} st_e;

  st_e           st;
  fmt_e          fmt_q;
  logic [7:0]    scr_q, div;
  logic [1:0]    lead;
  logic          trail_next;
  logic [3:0]    idx;
  logic [DW-1:0] tx_q, rx_q;
  logic          can_go, step, rx_bit;

  assign can_go  = enable && (fmt == FMT_SPI || fmt == FMT_TI) && !tx_empty;
  assign tx_pop  = (st == S_IDLE) && can_go;
  assign step    = (div == scr_q);
  assign rx_bit  = lpbk ? txd : rxd;
  assign rx_word = rx_q;
  assign active  = (st == S_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      fmt_q      <= FMT_SPI;
      scr_q      <= '0;
      div        <= '0;
      lead       <= '0;
      trail_next <= 1'b0;
      idx        <= '0;
      tx_q       <= '0;
      rx_q       <= '0;
      rx_push    <= 1'b0;
      sclk       <= 1'b0;
      sfrm       <= 1'b1;
      txd        <= 1'b0;
    end else begin
      rx_push <= 1'b0;
      case (st)
        S_IDLE: begin
          sclk <= pol;
          sfrm <= (fmt != FMT_TI);
          txd  <= 1'b0;
          if (can_go) begin
            st         <= S_RUN;
            fmt_q      <= fmt;
            scr_q      <= scr;
            div        <= '0;
            trail_next <= 1'b0;
            lead       <= (fmt == FMT_TI) ? 2'd2 : (pha ? 2'd0 : 2'd1);
            tx_q       <= tx_word;
            idx        <= dsz;
            txd        <= tx_word[dsz];
            rx_q       <= '0;
            sfrm       <= (fmt == FMT_TI);
          end
        end
        default: begin
          div <= step ? 8'd0 : div + 8'd1;
          if (step) begin
            if (lead != 2'd0) begin
              lead <= lead - 2'd1;
              if (lead == 2'd1 && fmt_q == FMT_TI) sfrm <= 1'b0;
            end else if (!trail_next) begin
              trail_next <= 1'b1;
              sclk       <= ~pol;
              rx_q       <= {rx_q[DW-2:0], rx_bit};
            end else begin
              trail_next <= 1'b0;
              sclk       <= pol;
              if (idx == 4'd0) begin
                st      <= S_IDLE;
                rx_push <= 1'b1;
                sfrm    <= (fmt_q != FMT_TI);
                txd     <= 1'b0;
              end else begin
                idx <= idx - 4'd1;
                txd <= tx_q[idx - 4'd1];
              end
            end
          end
        end
      endcase
    end
  end

  // R3
  enable_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && !enable) |=> (st == S_IDLE));

  // R4
  spi_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_RUN && fmt_q == FMT_SPI) |-> !sfrm);

  // R5
  ti_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_RUN && fmt_q == FMT_TI && lead == 2'd0) |-> !sfrm);
endmodule

// File: rtl/ssp_engine.sv
module ssp_engine import ssp_pkg::*; #(
  parameter int FIFO_DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          sclk,
  output logic          sfrm,
  output logic          txd,
  input  logic          rxd,
  output logic          tx_irq,
  output logic          rx_irq
);
  localparam int CW   = $clog2(FIFO_DEPTH) + 1;
  localparam int HALF = FIFO_DEPTH / 2;

  addr_e         a;
  ctrl0_t        c0;
  ctrl1_t        c1;
  logic          ovr;
  logic          tx_push, tx_pop, tx_full, tx_empty;
  logic          rx_push, rx_pop, rx_full, rx_empty;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [DW-1:0] tx_dout, rx_dout, rx_word;
  logic          active, busy, tx_half, rx_half;
  logic [DW-1:0] stat;

  assign a       = addr_e'(addr);
  assign tx_push = wr_en && a == A_DATA;
  assign rx_pop  = rd_en && a == A_DATA;
  assign tx_half = (tx_cnt <= CW'(HALF));
  assign rx_half = (rx_cnt >= CW'(HALF));
  assign busy    = active || (c0.en && !tx_empty);
  assign stat    = {{(DW-6){1'b0}}, ovr, rx_half, tx_half, busy, !rx_empty, !tx_full};

  ssp_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(tx_push), .pop(tx_pop), .din(wdata),
    .dout(tx_dout), .full(tx_full), .empty(tx_empty), .count(tx_cnt));

  ssp_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(rx_push), .pop(rx_pop), .din(rx_word),
    .dout(rx_dout), .full(rx_full), .empty(rx_empty), .count(rx_cnt));

  ssp_shift u_shift (
    .clk(clk), .rst(rst), .enable(c0.en), .fmt(c0.fmt), .dsz(c0.dsz),
    .scr(c0.scr), .pol(c1.pol), .pha(c1.pha), .lpbk(c1.lpbk),
    .tx_empty(tx_empty), .tx_word(tx_dout), .rxd(rxd), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_word(rx_word), .active(active),
    .sclk(sclk), .sfrm(sfrm), .txd(txd));

  always_ff @(posedge clk) begin
    if (rst) begin
      c0     <= '0;
      c1     <= '0;
      ovr    <= 1'b0;
      rdata  <= '0;
      tx_irq <= 1'b0;
      rx_irq <= 1'b0;
    end else begin
      if (wr_en && a == A_CTRL0) c0 <= ctrl0_t'(wdata);
      if (wr_en && a == A_CTRL1) c1 <= ctrl1_t'(wdata);
      if (rx_push && rx_full)                   ovr <= 1'b1;
      else if (wr_en && a == A_STAT && wdata[5]) ovr <= 1'b0;
      if (rd_en) begin
        case (a)
          A_CTRL0: rdata <= c0;
          A_CTRL1: rdata <= c1;
          A_DATA:  rdata <= rx_empty ? '0 : rx_dout;
          default: rdata <= stat;
        endcase
      end
      tx_irq <= c1.tx_ie && tx_half;
      rx_irq <= c1.rx_ie && rx_half;
    end
  end

  // R12
  overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_push && rx_full) |=> ovr);

  // R12
  overrun_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_push && rx_full && !rx_pop) |=> $stable(rx_cnt));
endmodule

// File: tb/ssp_engine_tb.sv
module ssp_engine_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        sclk, sfrm, txd, rxd, tx_irq, rx_irq;

  // the outside world returns the inverse of what was sent
  assign rxd = ~txd;

  ssp_engine u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sclk(sclk), .sfrm(sfrm), .txd(txd),
    .rxd(rxd), .tx_irq(tx_irq), .rx_irq(rx_irq));

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic xfer(input int sz, input int fmt, input int pol, input int pha,
                      input int scr, input int lb, input logic [15:0] w);
    logic [15:0] m, cap, d;
    int tf, tfe, tl1, tl2, nl;
    bit spi_bad;
    logic ps;
    m = 16'((32'd1 << sz) - 1);
    cap = '0; tf = -1; tfe = -1; tl1 = -1; tl2 = -1; nl = 0; spi_bad = 0;
    wr(2'd1, 16'(pha * 16 + pol * 8 + lb * 4));
    wr(2'd0, 16'(scr * 256 + 128 + fmt * 16 + (sz - 1)));
    wr(2'd2, w);
    ps = sclk;
    for (int t = 1; t <= 3000; t++) begin
      @(negedge clk);
      if (tf < 0 && sfrm == (fmt == 1)) tf = t;
      if (fmt == 1 && tf >= 0 && tfe < 0 && !sfrm) tfe = t;
      if (sclk !== ps && sclk == ~pol[0]) begin
        nl++;
        cap = {cap[14:0], txd};
        if (nl == 1) tl1 = t;
        if (nl == 2) tl2 = t;
        if (fmt == 0 && sfrm) spi_bad = 1;
      end
      ps = sclk;
      if (nl == sz && sclk == pol[0] && sfrm == (fmt == 0)) break;
    end
    chk("R1 leading edge count", nl, sz);
    chk("R1 serial word MSB first", cap & m, w & m);
    chk("R2 bit period", tl2 - tl1, 2 * (scr + 1));
    if (fmt == 0) begin
      chk("R7 first edge delay", tl1 - tf, (pha ? 1 : 2) * (scr + 1));
      chk("R4 frame low on every edge", spi_bad, 0);
    end else begin
      chk("R5 pulse width", tfe - tf, 2 * (scr + 1));
      chk("R5 first edge after pulse", tl1 - tfe, scr + 1);
    end
    chk("R6 clock idle level", sclk, pol);
    repeat (3) @(negedge clk);
    rd(2'd2, d);
    chk("R8 R9 received word", d, lb ? (w & m) : (~w & m));
    rd(2'd3, d);
    chk("R11 status after word", d, 16'h0009);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual expired expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int viol;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    rd(2'd3, d);
    chk("R11 status at reset", d, 16'h0009);
    chk("R6 clock idle after reset", sclk, 0);
    chk("R4 frame idle after reset", sfrm, 1);

    // R3 port disabled holds the queued word
    wr(2'd1, 16'h0004);
    wr(2'd0, 16'h0107);
    wr(2'd2, 16'h005A);
    viol = 0;
    repeat (40) begin
      @(negedge clk);
      if (!sfrm || sclk) viol++;
    end
    chk("R3 no frame while disabled", viol, 0);
    rd(2'd3, d);
    chk("R3 status while disabled", d, 16'h0009);
    wr(2'd0, 16'h0187);
    rd(2'd3, d);
    chk("R11 busy while shifting", d[2], 1);
    repeat (100) @(negedge clk);
    rd(2'd2, d);
    chk("R3 word sent after enable", d, 16'h005A);

    // R4 unsupported format starts nothing
    wr(2'd0, 16'h01A7);
    wr(2'd2, 16'h003C);
    viol = 0;
    repeat (40) begin
      @(negedge clk);
      if (!sfrm || sclk) viol++;
    end
    chk("R4 format 2 starts no frame", viol, 0);
    wr(2'd0, 16'h0187);
    repeat (100) @(negedge clk);
    rd(2'd2, d);
    chk("R4 word kept until format 0", d, 16'h003C);
    rd(2'd2, d);
    chk("R9 empty read returns zero", d, 16'h0000);

    // R1 R2 R4 R5 R6 R7 R8 sweep of every size, format, polarity and phase
    for (int sz = 4; sz <= 16; sz++)
      for (int fmt = 0; fmt <= 1; fmt++)
        for (int pol = 0; pol <= 1; pol++)
          for (int pha = 0; pha <= 1; pha++)
            xfer(sz, fmt, pol, pha, sz % 3, (sz + pha) % 2,
                 16'(32'h9E37 * (sz * 8 + fmt * 4 + pol * 2 + pha + 1)));

    // R10 R12 R13 queue depth, overrun and service requests
    wr(2'd0, 16'h0003);
    wr(2'd1, 16'h0007);
    repeat (2) @(negedge clk);
    chk("R13 tx request when empty", tx_irq, 1);
    chk("R13 rx request when empty", rx_irq, 0);
    for (int i = 1; i <= 9; i++) wr(2'd2, 16'(i));
    rd(2'd3, d);
    chk("R10 status with full transmit queue", d, 16'h0000);
    chk("R13 tx request off when full", tx_irq, 0);
    wr(2'd0, 16'h0083);
    repeat (200) @(negedge clk);
    rd(2'd3, d);
    chk("R11 status with full receive queue", d, 16'h001B);
    chk("R13 rx request at half or more", rx_irq, 1);
    wr(2'd2, 16'h000F);
    repeat (60) @(negedge clk);
    rd(2'd3, d);
    chk("R12 overrun flagged", d, 16'h003B);
    wr(2'd3, 16'h0020);
    rd(2'd3, d);
    chk("R12 overrun cleared by write", d, 16'h001B);
    for (int i = 1; i <= 8; i++) begin
      rd(2'd2, d);
      chk("R10 R12 receive order", d, 16'(i));
    end
    rd(2'd2, d);
    chk("R12 late word discarded", d, 16'h0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule